// File: doc/BRIEF.md
# DRAM Refresh Mode Decoder and Row Counter

This block models the refresh-control section of a dynamic memory device, for use as a checking model or an emulation target. It samples the active-low row strobe, column strobe and write-enable on each rising clock edge. It reads the order in which the strobes change, and from that order it sorts every falling edge of the row strobe into one of five cases: an ordinary access, a refresh that uses the row given on the address pins, a refresh with column-before-row order, a hidden refresh, or a reserved test-entry combination. Refreshes that supply no address take their row from an internal 12-bit counter. Each refresh that completes produces a one-cycle pulse together with the refreshed row and a kind code.

On the low-power variant, the block enters self-refresh when both strobes stay low in column-before-row order past a threshold. While in self-refresh, an internal interval timer issues refreshes from the counter until the row strobe returns high. A parameter selects the 8K variant or the 4K variant. That choice sets the width of the address used by address-supplied refreshes, which is 13 or 12 bits. The counter stays 12 bits wide in both variants.

The controller has seven states. IDLE means the row strobe is high. RAS_PEND means the row strobe has fallen with the column strobe high and the cycle is not yet classified. ACCESS is an ordinary access. CBR is a counter refresh. HIDDEN is a counter refresh that follows a read while the column strobe is still held low. SELF is self-refresh. TEST_IGN is the reserved combination, which the block ignores. The transitions are as follows:
- IDLE goes to RAS_PEND, CBR, HIDDEN or TEST_IGN on a row-strobe fall, depending on the column strobe, write-enable and the held-read flag.
- RAS_PEND goes to ACCESS on a column-strobe fall, or back to IDLE on a row-strobe rise, and that rise issues the address refresh.
- CBR goes to SELF when the entry threshold is reached, or to IDLE on a rise.
- ACCESS, HIDDEN, SELF and TEST_IGN each return to IDLE on a row-strobe rise.

Top module: `strobe_refresh_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, rf_pulse, test_err, in_self, in_access and hold_read are all 0, and the internal row counter starts at 0.
- R2: If the row strobe falls while the column strobe is high, and the column strobe stays high until the row strobe rises, then the cycle after the edge that samples the row strobe high shows rf_pulse=1 and rf_kind=0. rf_row holds the address sampled at the falling edge: all 13 bits when EIGHT_K=1, or the low 12 bits when EIGHT_K=0. The counter does not change.
- R3: If the column strobe falls while the row strobe is low, after the row strobe fell with the column strobe high, the cycle is an access. in_access is 1 from the cycle after that column-strobe sample until the row strobe is sampled high. The access produces no refresh pulse.
- R4: If the row strobe falls while the column strobe is low, write-enable is high and hold_read is 0, the cycle is a counter refresh. On the row-strobe rise it pulses with rf_kind=1 and rf_row equal to the counter value, zero-extended. The address pins are ignored. The counter then advances by one.
- R5: The row counter wraps from 4095 to 0.
- R6: If an access ends with the row strobe rising while the column strobe is still low, hold_read goes to 1 and stays at 1 until the column strobe is sampled high. If the row strobe falls again while hold_read is 1, the result is a hidden refresh: rf_kind=2, the row comes from the counter, and the counter advances.
- R7: With LOW_POWER=1, a counter refresh in which both strobes stay low for SR_ENTRY_CYC sampled edges after the entering edge enters self-refresh. in_self goes to 1, and an entry pulse with rf_kind=3 refreshes the counter row.
- R8: While in self-refresh, one refresh with rf_kind=3 is issued from the counter every SR_TICK_CYC cycles, and each one advances the counter.
- R9: A row-strobe rise ends self-refresh. If the rise comes on the same edge at which the interval timer expires, the rise takes priority: no pulse is issued and the counter does not change.
- R10: With LOW_POWER=0, self-refresh is never entered. A long counter refresh completes with rf_kind=1 when the row strobe rises.
- R11: If the row strobe falls while both the column strobe and write-enable are low, test_err pulses for one cycle. That cycle then issues no refresh and leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write-enable, active low |
| addr | input | ROW_W | Row address for address-supplied refresh (13 bits for 8K, 12 bits for 4K) |
| rf_pulse | output | 1 | One-cycle pulse when a refresh is done |
| rf_kind | output | 2 | 0 address, 1 counter, 2 hidden, 3 self |
| rf_row | output | ROW_W | Row refreshed, valid with rf_pulse |
| test_err | output | 1 | One-cycle pulse on the reserved test-entry combination |
| in_self | output | 1 | Self-refresh active |
| in_access | output | 1 | Ordinary access in progress |
| hold_read | output | 1 | Read data must stay driven during a hidden refresh |

## Verification
Two events can land on the same clock edge: the self-refresh interval timer expiring, and the row strobe rising to end self-refresh. The bench waits until it first sees in_self. It then counts cycles so that the row strobe is sampled high on exactly the edge where the third interval would fire. The check passes only if no pulse appears, and if the next counter refresh reports the row that follows the last self-refresh row.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAS_PEND,
        ST_ACCESS,
        ST_CBR,
        ST_HIDDEN,
        ST_SELF,
        ST_TEST_IGN
    } rfsh_state_e;

    typedef enum logic [1:0] {
        RK_ROW_ONLY = 2'd0,
        RK_CBR      = 2'd1,
        RK_HIDDEN   = 2'd2,
        RK_SELF     = 2'd3
    } rfsh_kind_e;

endpackage

// File: rtl/rfsh_row_counter.sv
module rfsh_row_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    // Free-running modulo-2^CNT_W counter for refreshes that use the internal row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rfsh_self_timer.sv
module rfsh_self_timer #(
    parameter int ENTRY_CYC = 64,
    parameter int TICK_CYC  = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_en,
    input  logic tick_en,
    output logic entry_hit,
    output logic tick_hit
);

    localparam int HOLD_W = $clog2(ENTRY_CYC + 1);
    localparam int TICK_W = $clog2(TICK_CYC + 1);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(ENTRY_CYC - 1);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICK_CYC - 1);

    logic [HOLD_W-1:0] hold_q;
    logic [TICK_W-1:0] tick_q;

    assign entry_hit = hold_en && (hold_q == HOLD_LAST);
    assign tick_hit  = tick_en && (tick_q == TICK_LAST);

    // Counts how long both strobes are held low during a counter refresh
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (hold_en && !entry_hit) begin
            hold_q <= hold_q + 1'b1;
        end else begin
            hold_q <= '0;
        end
    end

    // Interval timer that runs only while self-refresh lasts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (tick_en) begin
            tick_q <= tick_hit ? '0 : tick_q + 1'b1;
        end else begin
            tick_q <= '0;
        end
    end

endmodule

// File: rtl/strobe_refresh_ctrl.sv
module strobe_refresh_ctrl
    import rfsh_pkg::*;
#(
    parameter int EIGHT_K      = 1,
    parameter int LOW_POWER    = 1,
    parameter int CNT_W        = 12,
    parameter int SR_ENTRY_CYC = 64,
    parameter int SR_TICK_CYC  = 32,
    localparam int ROW_W       = CNT_W + ((EIGHT_K != 0) ? 1 : 0)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [ROW_W-1:0] addr,
    output logic             rf_pulse,
    output logic [1:0]       rf_kind,
    output logic [ROW_W-1:0] rf_row,
    output logic             test_err,
    output logic             in_self,
    output logic             in_access,
    output logic             hold_read
);

    rfsh_state_e      state_q, state_d;
    rfsh_kind_e       ev_kind;
    logic             ev_pulse, ev_use_lat, ev_err;
    logic             cnt_inc, lat_load;
    logic             held_q, held_d;
    logic [ROW_W-1:0] lat_row_q;
    logic [CNT_W-1:0] cnt_q;
    logic [ROW_W-1:0] cnt_row;
    logic             hold_en, tick_en, entry_hit, tick_hit, sr_enter;

    assign cnt_row = ROW_W'(cnt_q);
    assign hold_en = (state_q == ST_CBR) && !ras_n && !cas_n;
    assign tick_en = (state_q == ST_SELF) && !ras_n;

    rfsh_row_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cnt_inc),
        .cnt   (cnt_q)
    );

    rfsh_self_timer #(.ENTRY_CYC(SR_ENTRY_CYC), .TICK_CYC(SR_TICK_CYC)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_en   (hold_en),
        .tick_en   (tick_en),
        .entry_hit (entry_hit),
        .tick_hit  (tick_hit)
    );

    // Self-refresh exists only on the low-power variant
    generate
        if (LOW_POWER != 0) begin : g_lp
            assign sr_enter = entry_hit;
        end else begin : g_np
            assign sr_enter = 1'b0;
        end
    endgenerate

    // Next state and events decoded from the order of the strobe edges
    always_comb begin
        state_d    = state_q;
        ev_pulse   = 1'b0;
        ev_kind    = RK_ROW_ONLY;
        ev_use_lat = 1'b0;
        ev_err     = 1'b0;
        cnt_inc    = 1'b0;
        lat_load   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!ras_n) begin
                    if (!cas_n) begin
                        if (!we_n) begin
                            state_d = ST_TEST_IGN;
                            ev_err  = 1'b1;
                        end else if (held_q) begin
                            state_d = ST_HIDDEN;
                        end else begin
                            state_d = ST_CBR;
                        end
                    end else begin
                        state_d  = ST_RAS_PEND;
                        lat_load = 1'b1;
                    end
                end
            end
            ST_RAS_PEND: begin
                if (ras_n) begin
                    state_d    = ST_IDLE;
                    ev_pulse   = 1'b1;
                    ev_kind    = RK_ROW_ONLY;
                    ev_use_lat = 1'b1;
                end else if (!cas_n) begin
                    state_d = ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                if (ras_n) begin
                    state_d = ST_IDLE;
                end
            end
            ST_CBR: begin
                if (ras_n) begin
                    state_d  = ST_IDLE;
                    ev_pulse = 1'b1;
                    ev_kind  = RK_CBR;
                    cnt_inc  = 1'b1;
                end else if (sr_enter) begin
                    state_d  = ST_SELF;
                    ev_pulse = 1'b1;
                    ev_kind  = RK_SELF;
                    cnt_inc  = 1'b1;
                end
            end
            ST_HIDDEN: begin
                if (ras_n) begin
                    state_d  = ST_IDLE;
                    ev_pulse = 1'b1;
                    ev_kind  = RK_HIDDEN;
                    cnt_inc  = 1'b1;
                end
            end
            ST_SELF: begin
                if (ras_n) begin
                    state_d = ST_IDLE;
                end else if (tick_hit) begin
                    ev_pulse = 1'b1;
                    ev_kind  = RK_SELF;
                    cnt_inc  = 1'b1;
                end
            end
            ST_TEST_IGN: begin
                if (ras_n) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Read data is held while the column strobe stays low past the end of an access
    always_comb begin
        if (cas_n) begin
            held_d = 1'b0;
        end else if ((state_q == ST_ACCESS) && ras_n) begin
            held_d = 1'b1;
        end else begin
            held_d = held_q;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            held_q    <= 1'b0;
            lat_row_q <= '0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
            if (lat_load) begin
                lat_row_q <= addr;
            end
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_pulse <= 1'b0;
            rf_kind  <= RK_ROW_ONLY;
            rf_row   <= '0;
            test_err <= 1'b0;
        end else begin
            rf_pulse <= ev_pulse;
            test_err <= ev_err;
            if (ev_pulse) begin
                rf_kind <= ev_kind;
                rf_row  <= ev_use_lat ? lat_row_q : cnt_row;
            end
        end
    end

    assign in_self   = (state_q == ST_SELF);
    assign in_access = (state_q == ST_ACCESS);
    assign hold_read = held_q;

endmodule

// File: rtl/rfsh_chk.sv
module rfsh_chk #(
    parameter int ROW_W     = 13,
    parameter int CNT_W     = 12,
    parameter int LOW_POWER = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic             rf_pulse,
    input logic [1:0]       rf_kind,
    input logic [ROW_W-1:0] rf_row,
    input logic             test_err,
    input logic             in_self,
    input logic             in_access,
    input logic [CNT_W-1:0] cnt
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!rf_pulse && !test_err && !in_self && !in_access));

    p_addr_refresh_keeps_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_pulse && rf_kind == 2'd0) |-> (cnt == $past(cnt)));

    p_nonself_pulse_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_pulse && rf_kind != 2'd3) |-> $past(ras_n));

    p_access_end_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_access && ras_n) |=> !rf_pulse);

    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_pulse && rf_kind != 2'd0) |->
            (cnt == CNT_W'($past(cnt) + 1'b1)) && (rf_row[CNT_W-1:0] == $past(cnt)));

    p_self_pulse_in_self_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_pulse && rf_kind == 2'd3) |-> in_self);

    p_self_exit_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_self && ras_n) |=> (!in_self && !rf_pulse));

    p_no_self_np_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (LOW_POWER == 0) |-> !in_self);

    p_err_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        test_err |=> (!test_err && !rf_pulse));

endmodule

bind strobe_refresh_ctrl rfsh_chk #(
    .ROW_W     (ROW_W),
    .CNT_W     (CNT_W),
    .LOW_POWER (LOW_POWER)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (ras_n),
    .rf_pulse  (rf_pulse),
    .rf_kind   (rf_kind),
    .rf_row    (rf_row),
    .test_err  (test_err),
    .in_self   (in_self),
    .in_access (in_access),
    .cnt       (cnt_q)
);

// File: tb/strobe_refresh_ctrl_test.sv
module strobe_refresh_ctrl_test;

    localparam int ENTRY = 6;
    localparam int TICK  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ras_n = 1'b1;
    logic        cas_n = 1'b1;
    logic        we_n  = 1'b1;
    logic [12:0] addr  = '0;

    logic        rf_pulse, test_err, in_self, in_access, hold_read;
    logic [1:0]  rf_kind;
    logic [12:0] rf_row;
    logic        np_pulse, np_err, np_self, np_access, np_hold;
    logic [1:0]  np_kind;
    logic [11:0] np_row;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    strobe_refresh_ctrl #(.EIGHT_K(1), .LOW_POWER(1), .SR_ENTRY_CYC(ENTRY), .SR_TICK_CYC(TICK)) uut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr),
        .rf_pulse(rf_pulse), .rf_kind(rf_kind), .rf_row(rf_row), .test_err(test_err),
        .in_self(in_self), .in_access(in_access), .hold_read(hold_read));

    strobe_refresh_ctrl #(.EIGHT_K(0), .LOW_POWER(0), .SR_ENTRY_CYC(ENTRY), .SR_TICK_CYC(TICK)) uut_np (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr[11:0]),
        .rf_pulse(np_pulse), .rf_kind(np_kind), .rf_row(np_row), .test_err(np_err),
        .in_self(np_self), .in_access(np_access), .hold_read(np_hold));

    // Behavioural reference: 0 idle,1 pend,2 access,3 cbr,4 hidden,5 self,6 ignored
    int ms = 0, mcnt = 0, mheld = 0, mhold = 0, mtick = 0, mlat = 0;
    int e_pulse = 0, e_kind = 0, e_row = 0, e_err = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mcnt = 0; mheld = 0; mhold = 0; mtick = 0; mlat = 0;
            e_pulse = 0; e_err = 0;
        end else begin
            e_pulse = 0;
            e_err   = 0;
            case (ms)
                0: if (!ras_n) begin
                       if (!cas_n) begin
                           if (!we_n) begin ms = 6; e_err = 1; end
                           else if (mheld != 0) ms = 4;
                           else begin ms = 3; mhold = 0; end
                       end else begin
                           ms = 1; mlat = int'(addr);
                       end
                   end
                1: if (ras_n) begin e_pulse = 1; e_kind = 0; e_row = mlat; ms = 0; end
                   else if (!cas_n) ms = 2;
                2: if (ras_n) begin ms = 0; if (!cas_n) mheld = 1; end
                3: if (ras_n) begin e_pulse = 1; e_kind = 1; e_row = mcnt; mcnt = (mcnt + 1) % 4096; ms = 0; end
                   else if (!cas_n) begin
                       if (mhold == ENTRY - 1) begin
                           e_pulse = 1; e_kind = 3; e_row = mcnt; mcnt = (mcnt + 1) % 4096;
                           ms = 5; mtick = 0;
                       end else mhold = mhold + 1;
                   end else mhold = 0;
                4: if (ras_n) begin e_pulse = 1; e_kind = 2; e_row = mcnt; mcnt = (mcnt + 1) % 4096; ms = 0; end
                5: if (ras_n) ms = 0;
                   else if (mtick == TICK - 1) begin
                       e_pulse = 1; e_kind = 3; e_row = mcnt; mcnt = (mcnt + 1) % 4096; mtick = 0;
                   end else mtick = mtick + 1;
                6: if (ras_n) ms = 0;
                default: ms = 0;
            endcase
            if (cas_n) mheld = 0;
        end
    end

    function automatic string req_of_kind(input int k);
        case (k)
            0: return "R2";
            1: return "R4";
            2: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic cmp(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison and capture of observed events
    int npulse = 0, nself = 0, nerr = 0, last_kind = 0, last_row = 0;
    int np_last_kind = 0, np_last_row = 0;
    bit np_self_seen = 0;

    always @(negedge clk) begin
        if (!done) begin
            cmp(req_of_kind(e_kind), "pulse", int'(rf_pulse), e_pulse);
            if (e_pulse != 0) begin
                cmp(req_of_kind(e_kind), "kind", int'(rf_kind), e_kind);
                cmp(req_of_kind(e_kind), "row", int'(rf_row), e_row);
            end
            cmp("R11", "test_err", int'(test_err), e_err);
            cmp("R7", "in_self", int'(in_self), (ms == 5) ? 1 : 0);
            cmp("R3", "in_access", int'(in_access), (ms == 2) ? 1 : 0);
            cmp("R6", "hold_read", int'(hold_read), mheld);
        end
        if (rf_pulse) begin
            npulse++;
            last_kind = int'(rf_kind);
            last_row  = int'(rf_row);
            if (rf_kind == 2'd3) nself++;
        end
        if (test_err) nerr++;
        if (np_pulse) begin
            np_last_kind = int'(np_kind);
            np_last_row  = int'(np_row);
        end
        if (np_self) np_self_seen = 1;
    end

    task automatic cyc(input logic r, input logic c, input logic w, input logic [12:0] a);
        @(negedge clk);
        ras_n = r; cas_n = c; we_n = w; addr = a;
    endtask

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    task automatic cbr_cycle();
        cyc(1'b1, 1'b0, 1'b1, 13'h0);
        cyc(1'b0, 1'b0, 1'b1, 13'h1FFF);
        cyc(1'b1, 1'b1, 1'b1, 13'h0);
    endtask

    initial begin
        int p0, start;
        repeat (3) @(negedge clk);
        #2;
        cmp("R1", "reset pulse", int'(rf_pulse), 0);
        cmp("R1", "reset self", int'(in_self), 0);
        cmp("R1", "reset hold_read", int'(hold_read), 0);
        rst_n = 1'b1;
        settle();
        cmp("R1", "idle after reset", int'(rf_pulse | test_err | in_access), 0);

        // R2: refresh with address from the pins
        p0 = npulse;
        cyc(1'b0, 1'b1, 1'b1, 13'h1ABC);
        cyc(1'b0, 1'b1, 1'b1, 13'h0);
        cyc(1'b1, 1'b1, 1'b1, 13'h0);
        settle();
        cmp("R2", "addr refresh count", npulse - p0, 1);
        cmp("R2", "addr refresh kind", last_kind, 0);
        cmp("R2", "addr refresh row 8K", last_row, 'h1ABC);
        cmp("R2", "addr refresh row 4K", np_last_row, 'hABC);

        // R4: counter refresh ignores pins
        cbr_cycle(); settle();
        cmp("R4", "cbr kind", last_kind, 1);
        cmp("R4", "cbr first row", last_row, 0);
        cbr_cycle(); settle();
        cmp("R4", "cbr second row", last_row, 1);

        // R3 then R6: access, held column strobe, hidden refresh
        p0 = npulse;
        cyc(1'b0, 1'b1, 1'b1, 13'h0123);
        cyc(1'b0, 1'b0, 1'b1, 13'h0);
        settle();
        cmp("R3", "in_access", int'(in_access), 1);
        cyc(1'b1, 1'b0, 1'b1, 13'h0);
        settle();
        cmp("R3", "access no pulse", npulse - p0, 0);
        cmp("R6", "hold_read set", int'(hold_read), 1);
        cyc(1'b0, 1'b0, 1'b1, 13'h0);
        cyc(1'b1, 1'b0, 1'b1, 13'h0);
        settle();
        cmp("R6", "hidden kind", last_kind, 2);
        cmp("R6", "hidden row", last_row, 2);
        cmp("R6", "hold_read kept", int'(hold_read), 1);
        cyc(1'b1, 1'b1, 1'b1, 13'h0);
        settle();
        cmp("R6", "hold_read cleared", int'(hold_read), 0);

        // R11: reserved test entry
        p0 = npulse;
        cyc(1'b1, 1'b0, 1'b0, 13'h0);
        cyc(1'b0, 1'b0, 1'b0, 13'h0);
        settle();
        cmp("R11", "err pulses", nerr, 1);
        cyc(1'b1, 1'b1, 1'b1, 13'h0);
        settle();
        cmp("R11", "no refresh", npulse - p0, 0);
        cbr_cycle(); settle();
        cmp("R11", "counter unchanged", last_row, 3);

        // R7, R8, R9: self-refresh with exit on the expiry edge
        p0 = nself;
        cyc(1'b1, 1'b0, 1'b1, 13'h0);
        cyc(1'b0, 1'b0, 1'b1, 13'h0);
        for (int i = 0; i < 40 && !in_self; i++) settle();
        cmp("R7", "self entered", int'(in_self), 1);
        cmp("R7", "entry row", last_row, 4);
        repeat (13) cyc(1'b0, 1'b0, 1'b1, 13'h0);
        cyc(1'b1, 1'b1, 1'b1, 13'h0);
        settle(); settle();
        cmp("R8", "self pulses", nself - p0, 3);
        cmp("R8", "last self row", last_row, 6);
        cmp("R9", "self exited", int'(in_self), 0);
        cmp("R10", "np never self", int'(np_self_seen), 0);
        cmp("R10", "np long cbr kind", np_last_kind, 1);
        cmp("R10", "np long cbr row", np_last_row, 4);
        cbr_cycle(); settle();
        cmp("R9", "no refresh on collision", last_row, 7);

        // R5: wrap of the internal counter
        start = mcnt;
        for (int i = 0; i < 4096; i++) cbr_cycle();
        settle();
        cmp("R5", "row before wrap", last_row, (start + 4095) % 4096);
        cbr_cycle(); settle();
        cmp("R5", "row after wrap", last_row, start);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule